// File: doc/BRIEF.md
# Function-Level-Reset Capability Register Slice

This block is a small slice of configuration space for one PCI-style function. It holds two 16-bit words. The first is a header word that advertises function-level-reset support. The second is a control/status word, through which software starts a function reset and checks whether any non-posted requests are still in flight. Accesses arrive on a simple byte-enabled 16-bit read/write port, and read data returns one cycle after the read strobe.

A static strap picks one of two header layouts:

- **Writable layout:** firmware sets the two capability flags once after power-up. Those flags then stay put through any function reset.
- **Fixed layout:** the word is constant and carries an identifier, a version and a length.

A write of 1 to the initiate bit yields a one-clock request to the reset sequencer, and that bit always reads back as 0. An internal saturating counter of issued-but-uncompleted non-posted requests drives the pending flag.

Top module: `flr_cap_regs`

## Requirements
- R1: With `strap_alt_i`=0, the header word (byte offsets E2h/E3h) reads as {6'b0, reset-cap flag at bit 9, pending-cap flag at bit 8, 8'h06}, and both flags are 0 after `rst_ni`.
- R2: With `strap_alt_i`=1, the header word reads 16'h2006 (ID 2h in bits 15:12, version 0h in bits 11:8, length 06h in bits 7:0). Writes to it change neither the stored flags nor their locks.
- R3: Bits 9:8 are write-once. The first header write with `cfg_be_i[1]`=1 under strap 0 stores them and locks them, whatever value is written. Later writes are ignored, and a write with only `cfg_be_i[0]` set touches neither the flags nor the locks.
- R4: Writing bit 9 as 1 also sets bit 8, so the pending-cap flag always reads 1 when the reset-cap flag does.
- R5: `func_rst_i` leaves bits 9:8 and their locks unchanged. Only `rst_ni` clears them.
- R6: The control word (E4h/E5h) reads 0 in every bit except bit 8, which is 1 exactly when the outstanding-request count is nonzero. Bit 0 always reads 0, and the word reads 0000h after reset.
- R7: A control write with `cfg_be_i[0]`=1 and `cfg_wdata_i[0]`=1 raises `flr_req_o` for exactly one cycle, on the cycle after the write edge. This happens only when reset capability is present, meaning bit 9 is set or `strap_alt_i`=1.
- R8: The 6-bit outstanding counter increments on `np_issue_i` alone and decrements on `np_complete_i` alone. It holds when both or neither are asserted, saturates at 63 and at 0, and is cleared by `func_rst_i`.
- R9: `cfg_rdata_o` shows the addressed word one cycle after `cfg_rd_i`, using the state from before that edge. It reads 0 after a cycle with no read, and after a read of any other offset. Word select ignores `cfg_addr_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| func_rst_i | input | 1 | Function reset, synchronous, active high |
| strap_alt_i | input | 1 | Header layout select: 0 writable, 1 fixed |
| cfg_addr_i | input | 8 | Byte offset of the access |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_be_i | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Registered read data |
| np_issue_i | input | 1 | A non-posted request was issued |
| np_complete_i | input | 1 | A completion arrived |
| flr_req_o | output | 1 | One-cycle function reset request |

## Verification
The hardest states to reach are the counter's saturation edges, because only the pending flag shows the count. A count stuck at 63 cannot be told apart from one that wrapped until it is drained again. The stimulus therefore issues 70 requests and then completes exactly 63, so the flag reads 0 only if the count saturated; it also completes requests at zero and then issues one, which shows that no underflow wrap occurred. The write-once locks are exposed the same way. A zero-valued first write is followed by a conflicting second write, and a strap change is made without reset, which shows that fixed-layout writes left the locks clear.

// File: rtl/flr_cap_pkg.sv
package flr_cap_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 16;
  localparam int unsigned WO_N   = 2;   // write-once flags: [1]=reset cap, [0]=pending cap
  localparam int unsigned WO_LSB = 8;

  localparam logic [CFG_AW-1:0] HDR_OFS = 8'hE2;
  localparam logic [CFG_AW-1:0] CTL_OFS = 8'hE4;
  localparam logic [7:0]        CAP_LEN = 8'h06;
  localparam logic [3:0]        CAP_ID  = 4'h2;
  localparam logic [3:0]        CAP_VER = 4'h0;
  localparam int unsigned       PEND_BIT = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HDR  = 2'd1,
    SEL_CTL  = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [CFG_AW-1:0] addr);
    if (addr[CFG_AW-1:1] == HDR_OFS[CFG_AW-1:1])      return SEL_HDR;
    else if (addr[CFG_AW-1:1] == CTL_OFS[CFG_AW-1:1]) return SEL_CTL;
    else                                              return SEL_NONE;
  endfunction
endpackage

// File: rtl/flr_hdr_reg.sv
module flr_hdr_reg
  import flr_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_alt_i,
  input  logic              wr_i,
  input  logic              be_hi_i,
  input  logic [7:0]        wdata_hi_i,
  output logic [CFG_DW-1:0] word_o,
  output logic              flr_cap_o,
  output logic [WO_N-1:0]   wo_q_o,
  output logic [WO_N-1:0]   lock_q_o
);
  logic [WO_N-1:0] wo_q, lock_q, wo_nxt;
  logic            wr_ok;

  // pending cap is forced whenever reset cap is written
  assign wo_nxt = {wdata_hi_i[1], wdata_hi_i[0] | wdata_hi_i[1]};
  assign wr_ok  = wr_i && be_hi_i && !strap_alt_i;

  for (genvar i = 0; i < WO_N; i++) begin : g_wo
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wo_q[i]   <= 1'b0;
        lock_q[i] <= 1'b0;
      end else if (wr_ok && !lock_q[i]) begin
        wo_q[i]   <= wo_nxt[i];
        lock_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (strap_alt_i) word_o = {CAP_ID, CAP_VER, CAP_LEN};
    else             word_o = {{(CFG_DW-WO_LSB-WO_N){1'b0}}, wo_q, CAP_LEN};
  end

  assign flr_cap_o = strap_alt_i | wo_q[1];
  assign wo_q_o    = wo_q;
  assign lock_q_o  = lock_q;
endmodule

// File: rtl/flr_np_cnt.sv
module flr_np_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             issue_i,
  input  logic             complete_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cnt_q <= '0;
    else if (clr_i)                                       cnt_q <= '0;
    else if (issue_i && !complete_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    else if (complete_i && !issue_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign pend_o = |cnt_q;
endmodule

// File: rtl/flr_ctl_reg.sv
module flr_ctl_reg
  import flr_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              be_lo_i,
  input  logic              init_bit_i,
  input  logic              cap_i,
  input  logic              pend_i,
  output logic [CFG_DW-1:0] word_o,
  output logic              req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= wr_i && be_lo_i && init_bit_i && cap_i;
  end

  // initiate bit is write-only: never stored, reads 0
  always_comb begin
    word_o           = '0;
    word_o[PEND_BIT] = pend_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/flr_cap_regs.sv
module flr_cap_regs
  import flr_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              func_rst_i,
  input  logic              strap_alt_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_rd_i,
  input  logic [1:0]        cfg_be_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic [CFG_DW-1:0] cfg_rdata_o,
  input  logic              np_issue_i,
  input  logic              np_complete_i,
  output logic              flr_req_o
);
  reg_sel_e          sel;
  logic [CFG_DW-1:0] hdr_word, ctl_word, rdata_q, rd_mux;
  logic              flr_cap, pend;
  logic [WO_N-1:0]   wo_q, lock_q;
  logic [CNT_W-1:0]  cnt;

  assign sel = decode_sel(cfg_addr_i);

  flr_hdr_reg u_hdr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_alt_i (strap_alt_i),
    .wr_i        (cfg_wr_i && sel == SEL_HDR),
    .be_hi_i     (cfg_be_i[1]),
    .wdata_hi_i  (cfg_wdata_i[15:8]),
    .word_o      (hdr_word),
    .flr_cap_o   (flr_cap),
    .wo_q_o      (wo_q),
    .lock_q_o    (lock_q)
  );

  flr_np_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (func_rst_i),
    .issue_i    (np_issue_i),
    .complete_i (np_complete_i),
    .cnt_o      (cnt),
    .pend_o     (pend)
  );

  flr_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i && sel == SEL_CTL),
    .be_lo_i    (cfg_be_i[0]),
    .init_bit_i (cfg_wdata_i[0]),
    .cap_i      (flr_cap),
    .pend_i     (pend),
    .word_o     (ctl_word),
    .req_o      (flr_req_o)
  );

  always_comb begin
    unique case (sel)
      SEL_HDR: rd_mux = hdr_word;
      SEL_CTL: rd_mux = ctl_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cfg_rd_i) rdata_q <= rd_mux;
    else               rdata_q <= '0;
  end

  assign cfg_rdata_o = rdata_q;
endmodule

// File: rtl/flr_cap_regs_chk.sv
module flr_cap_regs_chk
  import flr_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              func_rst_i,
  input logic              cfg_wr_i,
  input logic              cfg_rd_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [1:0]        cfg_be_i,
  input logic [CFG_DW-1:0] cfg_wdata_i,
  input logic [CFG_DW-1:0] cfg_rdata_o,
  input logic              np_issue_i,
  input logic              np_complete_i,
  input logic              flr_req_o,
  input logic [WO_N-1:0]   wo_q,
  input logic [WO_N-1:0]   lock_q,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_txp_with_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wo_q[1] |-> wo_q[0]);

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(&lock_q) |-> $stable(wo_q));

  p_func_rst_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_rst_i && !cfg_wr_i) |=> ($stable(wo_q) && $stable(lock_q)));

  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flr_req_o |=> !flr_req_o);

  p_req_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flr_req_o |-> $past(cfg_wr_i && cfg_be_i[0] && cfg_wdata_i[0]
                        && cfg_addr_i[CFG_AW-1:1] == CTL_OFS[CFG_AW-1:1]));

  p_cnt_sat_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX && np_issue_i && !np_complete_i && !func_rst_i) |=> cnt == CNT_MAX);

  p_cnt_sat_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && np_complete_i && !np_issue_i) |=> cnt == '0);

  p_cnt_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_rst_i |=> cnt == '0);

  p_rdata_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rd_i |=> cfg_rdata_o == '0);

  p_ctl_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_addr_i[CFG_AW-1:1] == CTL_OFS[CFG_AW-1:1])
      |=> (cfg_rdata_o & 16'hFEFF) == 16'h0000);
endmodule

bind flr_cap_regs flr_cap_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .func_rst_i    (func_rst_i),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_rd_i      (cfg_rd_i),
  .cfg_addr_i    (cfg_addr_i),
  .cfg_be_i      (cfg_be_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .np_issue_i    (np_issue_i),
  .np_complete_i (np_complete_i),
  .flr_req_o     (flr_req_o),
  .wo_q          (wo_q),
  .lock_q        (lock_q),
  .cnt           (cnt)
);

// File: tb/sim_flr_cap_regs.sv
module sim_flr_cap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        func_rst = 1'b0, strap = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        issue = 1'b0, comp = 1'b0;
  logic        req;

  int    total = 0, bad = 0;
  string tag = "R6";

  always #10ns clk = ~clk;

  flr_cap_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .func_rst_i(func_rst), .strap_alt_i(strap),
    .cfg_addr_i(addr), .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .np_issue_i(issue),
    .np_complete_i(comp), .flr_req_o(req)
  );

  // behavioural reference model
  int          m_cap, m_txp, m_lk_c, m_lk_t, m_cnt;
  logic [15:0] exp_rdata;
  logic        exp_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap = 0; m_txp = 0; m_lk_c = 0; m_lk_t = 0; m_cnt = 0;
      exp_rdata = 16'h0; exp_req = 1'b0;
    end else begin
      int hdr, ctl, cap_eff;
      bit is_hdr, is_ctl;
      is_hdr  = (addr == 8'hE2 || addr == 8'hE3);
      is_ctl  = (addr == 8'hE4 || addr == 8'hE5);
      hdr     = strap ? 16'h2006 : ((m_cap << 9) | (m_txp << 8) | 6);
      ctl     = (m_cnt != 0) ? 16'h0100 : 16'h0000;
      cap_eff = strap ? 1 : m_cap;
      exp_rdata = !rd ? 16'h0 : is_hdr ? 16'(hdr) : is_ctl ? 16'(ctl) : 16'h0;
      exp_req   = wr && is_ctl && be[0] && wdata[0] && (cap_eff != 0);
      if (wr && is_hdr && be[1] && !strap) begin
        if (m_lk_c == 0) begin m_cap = int'(wdata[9]); m_lk_c = 1; end
        if (m_lk_t == 0) begin m_txp = int'(wdata[8] | wdata[9]); m_lk_t = 1; end
      end
      if (func_rst)                        m_cnt = 0;
      else if (issue && !comp && m_cnt < 63) m_cnt++;
      else if (comp && !issue && m_cnt > 0)  m_cnt--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rdata !== exp_rdata) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rdata);
      end
      total++;
      if (req !== exp_req) begin
        bad++;
        $display("FAIL %s flr_req actual=%b expected=%b", tag, req, exp_req);
      end
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [1:0] b, input logic [15:0] d,
                     input logic iss, input logic cmp, input logic fr);
    @(negedge clk);
    wr = w; rd = r; addr = a; be = b; wdata = d; issue = iss; comp = cmp; func_rst = fr;
  endtask

  task automatic wr16(input logic [7:0] a, input logic [1:0] b, input logic [15:0] d);
    cyc(1, 0, a, b, d, 0, 0, 0);
  endtask
  task automatic rd16(input logic [7:0] a);
    cyc(0, 1, a, 2'b11, 16'h0, 0, 0, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 2'b00, 16'h0, 0, 0, 0);
  endtask
  task automatic np(input logic iss, input logic cmp, input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 2'b00, 16'h0, iss, cmp, 0);
  endtask
  task automatic por(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    wr = 0; rd = 0; issue = 0; comp = 0; func_rst = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(20ns * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por(1'b0);
    // R6 reset state at the ports
    tag = "R6"; total++;
    if (rdata !== 16'h0 || req !== 1'b0) begin
      bad++; $display("FAIL R6 reset actual=%h/%b expected=0000/0", rdata, req);
    end
    tag = "R1"; rd16(8'hE2); idle(1);
    tag = "R6"; rd16(8'hE4); idle(1);
    tag = "R7"; wr16(8'hE4, 2'b01, 16'h0001); idle(2);           // no cap: no pulse
    tag = "R3"; wr16(8'hE2, 2'b01, 16'h0300); rd16(8'hE2); idle(1);
    tag = "R4"; wr16(8'hE2, 2'b10, 16'h0200); rd16(8'hE2); idle(1);
    tag = "R3"; wr16(8'hE2, 2'b11, 16'h0000); rd16(8'hE3); idle(1);
    tag = "R7"; wr16(8'hE4, 2'b11, 16'h0001); idle(2);
    wr16(8'hE5, 2'b10, 16'h0001); wr16(8'hE4, 2'b01, 16'h0000);
    wr16(8'hE4, 2'b01, 16'hFFFF); rd16(8'hE4); idle(2);
    tag = "R8"; np(1, 0, 3); rd16(8'hE4); np(1, 1, 4); np(0, 1, 2); rd16(8'hE4);
    np(0, 1, 1); rd16(8'hE4); np(0, 1, 3); np(1, 0, 1); rd16(8'hE5);
    np(0, 1, 1); rd16(8'hE4);
    np(1, 0, 70); rd16(8'hE4); np(0, 1, 62); rd16(8'hE4); np(0, 1, 1); rd16(8'hE4);
    tag = "R5"; np(1, 0, 2); rd16(8'hE4);
    cyc(0, 0, 8'h00, 2'b00, 16'h0, 0, 0, 1);
    rd16(8'hE4); rd16(8'hE2); idle(1);
    tag = "R5"; por(1'b0); rd16(8'hE2); idle(1);
    tag = "R3"; wr16(8'hE2, 2'b10, 16'h0000); wr16(8'hE2, 2'b10, 16'h0300);
    rd16(8'hE2); wr16(8'hE4, 2'b01, 16'h0001); idle(2);
    tag = "R9"; rd16(8'hE6); rd16(8'hE0); rd16(8'hE3); rd16(8'hE5); idle(1);
    cyc(1, 1, 8'hE2, 2'b10, 16'h0300, 0, 0, 0); idle(1);
    tag = "R2"; por(1'b1); rd16(8'hE2); wr16(8'hE2, 2'b11, 16'h0300); rd16(8'hE2);
    tag = "R7"; wr16(8'hE4, 2'b01, 16'h0001); idle(2);
    tag = "R2"; @(negedge clk); strap = 1'b0; rd16(8'hE2);
    wr16(8'hE2, 2'b10, 16'h0200); rd16(8'hE2); idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule